// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block is the watchdog of a small microcontroller. A tick from a free-running watchdog oscillator moves a 6-bit prescaler. Each time the prescaler wraps, it advances one final divider bit. When that final bit is set and the prescaler wraps again, the watchdog has timed out. At that point it raises a reset request and sets a sticky status flag. A normal time-out requests a full device reset. A time-out while the power-down indicator is high requests only a reduced reset, which covers the program counter and the stack pointer.

Software keeps the watchdog from timing out by clearing it. A software clear or a halt resets only the final divider bit. The prescaler keeps its residual count, so the interval from a clear to the next time-out varies by up to a factor of two. A static mode input chooses how software clears. In single mode, one clear strobe is enough. In paired mode, two distinct half-commands must both arrive before the clear takes effect. The external reset (`rst_ni`, asynchronous, active low) clears the whole chain and the status flag.

Top module: `wdog_pair_clr`

## Requirements
- R1: With `en_i` high after reset, the first time-out happens on the 128th cycle in which `tick_i` is high. Cycles with `tick_i` low do not advance the chain.
- R2: A software clear resets only the final divider bit. If the prescaler holds r after the clear, the next time-out happens on the (128 - r)th tick after it, so the interval is between 65 and 128 ticks.
- R3: While `en_i` is low, the chain holds its count, no time-out occurs, and `clr_i`, `clr_a_i`, `clr_b_i` and `halt_i` have no effect.
- R4: With `mode_pair_i` = 0 (single mode), a `clr_i` strobe clears the watchdog, and `clr_a_i` and `clr_b_i` are ignored.
- R5: With `mode_pair_i` = 1 (paired mode), `clr_i` is ignored. A clear takes effect once both `clr_a_i` and `clr_b_i` have been seen, in either order or in the same cycle. Repeating the same half does not clear.
- R6: In paired mode, a half that is pending is discarded by a completed clear, by `halt_i`, or by reset. A later single half therefore does not clear.
- R7: `halt_i` clears the final divider bit in both modes, in the same way as a software clear.
- R8: With `pdown_i` low, a time-out gives a one-cycle pulse on `dev_rst_o` in the cycle after the overflowing tick and sets `timeout_o`. `pc_rst_o` stays low.
- R9: With `pdown_i` high, a time-out gives a one-cycle pulse on `pc_rst_o` and sets `timeout_o`. `dev_rst_o` stays low.
- R10: `timeout_o` stays set until `rst_ni` goes low. `rst_ni` low clears all outputs and state at once, without waiting for a clock edge.
- R11: If a clear arrives on the same tick that would overflow, the clear wins and no time-out occurs. The next time-out follows 128 ticks later.
- R12: After a time-out the chain restarts from zero, so the next time-out follows 128 ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | External reset, asynchronous, active low |
| tick_i | input | 1 | One-cycle watchdog oscillator tick |
| en_i | input | 1 | Configuration enable |
| mode_pair_i | input | 1 | 0: single clear, 1: paired clear |
| clr_i | input | 1 | Single clear strobe |
| clr_a_i | input | 1 | First half of paired clear |
| clr_b_i | input | 1 | Second half of paired clear |
| halt_i | input | 1 | Halt strobe, clears the watchdog |
| pdown_i | input | 1 | Power-down indicator |
| dev_rst_o | output | 1 | Full device-reset pulse |
| pc_rst_o | output | 1 | Reduced reset pulse (program counter and stack pointer) |
| timeout_o | output | 1 | Sticky time-out flag |

## Verification
Some properties are checked on every cycle:
- the two reset pulses never occur together and each lasts a single cycle;
- the power-down indicator picks which of the two pulses occurs;
- the status flag is sticky, and it rises only together with a pulse;
- no pulse follows an idle tick, a disabled cycle or an accepted clear.

Other behaviour depends on the history of the chain, so only the bench scenarios can show it:
- the exact tick count to a time-out after a clear with a given residual prescaler value;
- whether a paired command sequence really cleared the watchdog;
- that pending halves are discarded by a halt or by a completed clear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    CLR_SINGLE = 1'b0,
    CLR_PAIR   = 1'b1
  } clr_mode_e;

  typedef struct packed {
    logic a_seen;
    logic b_seen;
  } pair_state_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PRE_W-1:0] cnt_o,
  output logic             carry_o
);
  localparam logic [PRE_W-1:0] PRE_MAX = '1;

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;  // wraps to zero
  end

  assign cnt_o   = cnt_q;
  assign carry_o = adv_i && (cnt_q == PRE_MAX);
endmodule

// File: rtl/wdog_final_stage.sv
module wdog_final_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic carry_i,
  input  logic clr_i,
  output logic stage_o,
  output logic ovf_o
);
  logic stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q <= 1'b0;
    else if (clr_i)   stage_q <= 1'b0;      // clear beats overflow
    else if (carry_i) stage_q <= ~stage_q;  // 1 -> 0 restarts the chain
  end

  assign stage_o = stage_q;
  assign ovf_o   = carry_i && stage_q && !clr_i;
endmodule

// File: rtl/wdog_clear_ctrl.sv
module wdog_clear_ctrl
  import wdog_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  clr_mode_e mode_i,
  input  logic      clr_i,
  input  logic      clr_a_i,
  input  logic      clr_b_i,
  input  logic      halt_i,
  output logic      clr_o
);
  pair_state_t pend_q, pend_d;
  logic hit_a, hit_b, pair_done, single_done, halt_clr;

  assign hit_a       = en_i && (mode_i == CLR_PAIR) && clr_a_i;
  assign hit_b       = en_i && (mode_i == CLR_PAIR) && clr_b_i;
  assign pair_done   = (hit_a && (pend_q.b_seen || hit_b)) || (hit_b && pend_q.a_seen);
  assign single_done = en_i && (mode_i == CLR_SINGLE) && clr_i;
  assign halt_clr    = en_i && halt_i;

  always_comb begin
    pend_d = pend_q;
    if (pair_done || halt_clr) begin
      pend_d = '0;
    end else begin
      if (hit_a) pend_d.a_seen = 1'b1;
      if (hit_b) pend_d.b_seen = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign clr_o = single_done || pair_done || halt_clr;
endmodule

// File: rtl/wdog_pair_clr.sv
module wdog_pair_clr
  import wdog_pkg::*;
#(
  parameter int PRE_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic mode_pair_i,
  input  logic clr_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic halt_i,
  input  logic pdown_i,
  output logic dev_rst_o,
  output logic pc_rst_o,
  output logic timeout_o
);
  logic             adv, carry, wd_clr, stage, ovf;
  logic [PRE_W-1:0] pre_cnt;
  clr_mode_e        mode;

  assign adv  = en_i && tick_i;
  assign mode = mode_pair_i ? CLR_PAIR : CLR_SINGLE;

  wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .cnt_o   (pre_cnt),
    .carry_o (carry)
  );

  wdog_clear_ctrl u_clr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .mode_i  (mode),
    .clr_i   (clr_i),
    .clr_a_i (clr_a_i),
    .clr_b_i (clr_b_i),
    .halt_i  (halt_i),
    .clr_o   (wd_clr)
  );

  wdog_final_stage u_fin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .carry_i (carry),
    .clr_i   (wd_clr),
    .stage_o (stage),
    .ovf_o   (ovf)
  );

  logic unused_pre;
  assign unused_pre = ^{pre_cnt, stage};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_rst_o <= 1'b0;
      pc_rst_o  <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      dev_rst_o <= ovf && !pdown_i;
      pc_rst_o  <= ovf && pdown_i;
      if (ovf) timeout_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_pair_clr_chk.sv
module wdog_pair_clr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic en_i,
  input logic mode_pair_i,
  input logic clr_i,
  input logic clr_a_i,
  input logic clr_b_i,
  input logic halt_i,
  input logic pdown_i,
  input logic dev_rst_o,
  input logic pc_rst_o,
  input logic timeout_o
);
  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_rst_o && pc_rst_o));
  p_dev_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_o |=> !dev_rst_o);
  p_pc_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_rst_o |=> !pc_rst_o);
  p_dev_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !pdown_i) |=> !pc_rst_o);
  p_pc_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pdown_i) |=> !dev_rst_o);
  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o);
  p_flag_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (dev_rst_o || pc_rst_o));
  p_pulse_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rst_o || pc_rst_o) |-> timeout_o);
  p_idle_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !(dev_rst_o || pc_rst_o));
  p_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(dev_rst_o || pc_rst_o));
  p_single_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !mode_pair_i && clr_i) |=> !(dev_rst_o || pc_rst_o));
  p_pair_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_pair_i && clr_a_i && clr_b_i) |=> !(dev_rst_o || pc_rst_o));
  p_halt_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && halt_i) |=> !(dev_rst_o || pc_rst_o));
endmodule

bind wdog_pair_clr wdog_pair_clr_chk u_chk (.*);

// File: tb/tb_wdog_pair_clr.sv
`timescale 1ns/1ps
module tb_wdog_pair_clr;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, en_i = 1'b1, mode_pair_i = 1'b0;
  logic clr_i = 1'b0, clr_a_i = 1'b0, clr_b_i = 1'b0, halt_i = 1'b0, pdown_i = 1'b0;
  logic dev_rst_o, pc_rst_o, timeout_o;

  int n_chk = 0, n_fail = 0, k = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  wdog_pair_clr dut (.*);

  // cmd: 0 clr_i, 1 A then B, 2 B then A, 3 A+B together, 4 A then A, 5 halt, 6 A+B in single mode
  typedef struct packed {
    logic       pair;
    logic [7:0] pre;
    logic [2:0] cmd;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd70,  3'd0, 8'd122},  // R2
    '{1'b0, 8'd127, 3'd0, 8'd65},   // R2 shortest
    '{1'b0, 8'd64,  3'd0, 8'd128},  // R2 longest
    '{1'b0, 8'd90,  3'd6, 8'd38},   // R4 halves ignored
    '{1'b0, 8'd110, 3'd5, 8'd82},   // R7
    '{1'b1, 8'd80,  3'd0, 8'd48},   // R5 clr_i ignored
    '{1'b1, 8'd80,  3'd1, 8'd112},  // R5
    '{1'b1, 8'd80,  3'd2, 8'd112},  // R5
    '{1'b1, 8'd80,  3'd3, 8'd112},  // R5
    '{1'b1, 8'd80,  3'd4, 8'd48},   // R5 repeat ignored
    '{1'b1, 8'd100, 3'd5, 8'd92}    // R7
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    {tick_i, clr_i, clr_a_i, clr_b_i, halt_i} = '0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic do_tick();
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic issue(input logic c, input logic a, input logic b, input logic h);
    @(negedge clk_i);
    {clr_i, clr_a_i, clr_b_i, halt_i} = {c, a, b, h};
    @(negedge clk_i);
    {clr_i, clr_a_i, clr_b_i, halt_i} = '0;
  endtask

  task automatic run_until(input int max_t, output int kk);
    kk = 0;
    for (int i = 1; i <= max_t; i++) begin
      do_tick();
      if (dev_rst_o || pc_rst_o) begin
        kk = i;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    do_reset();
    check(!timeout_o && !dev_rst_o && !pc_rst_o, "R10 reset", timeout_o, 0);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      do_reset();
      mode_pair_i = VECS[v].pair;
      ticks(int'(VECS[v].pre));
      case (VECS[v].cmd)
        3'd0: issue(1, 0, 0, 0);
        3'd1: begin issue(0, 1, 0, 0); issue(0, 0, 1, 0); end
        3'd2: begin issue(0, 0, 1, 0); issue(0, 1, 0, 0); end
        3'd3: issue(0, 1, 1, 0);
        3'd4: begin issue(0, 1, 0, 0); issue(0, 1, 0, 0); end
        3'd5: issue(0, 0, 0, 1);
        default: issue(0, 1, 1, 0);
      endcase
      run_until(200, k);
      check(k == int'(VECS[v].exp), $sformatf("R2/R4/R5/R7 vec %0d", v), k, int'(VECS[v].exp));
      check(dev_rst_o && timeout_o, "R8 vec pulse", dev_rst_o, 1);
    end
    mode_pair_i = 1'b0;

    // R1 R8 R12 R10
    do_reset();
    run_until(200, k);
    check(k == 128, "R1 first time-out", k, 128);
    check(dev_rst_o && !pc_rst_o && timeout_o, "R8 outputs", {dev_rst_o, pc_rst_o, timeout_o}, 3'b101);
    @(negedge clk_i);
    check(!dev_rst_o, "R8 single cycle", dev_rst_o, 0);
    run_until(200, k);
    check(k == 128, "R12 restart", k, 128);
    @(negedge clk_i);
    check(timeout_o, "R10 sticky", timeout_o, 1);
    #2 rst_ni = 1'b0;
    #1 check(!timeout_o, "R10 async clear", timeout_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R9
    pdown_i = 1'b1;
    do_reset();
    run_until(200, k);
    check(k == 128 && pc_rst_o && !dev_rst_o && timeout_o, "R9 power-down", k, 128);
    pdown_i = 1'b0;

    // R3 disabled: no count, clears ignored
    do_reset();
    en_i = 1'b0;
    run_until(300, k);
    check(k == 0 && !timeout_o, "R3 no time-out", k, 0);
    en_i = 1'b1;
    ticks(100);
    en_i = 1'b0;
    issue(1, 0, 0, 0);
    issue(0, 0, 0, 1);
    en_i = 1'b1;
    run_until(200, k);
    check(k == 28, "R3 clears ignored", k, 28);

    // R11 clear on overflowing tick
    do_reset();
    ticks(127);
    @(negedge clk_i);
    tick_i = 1'b1;
    clr_i  = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    clr_i  = 1'b0;
    check(!dev_rst_o && !timeout_o, "R11 clear wins", dev_rst_o, 0);
    run_until(200, k);
    check(k == 128, "R11 next time-out", k, 128);

    // R6 halt discards a pending half
    do_reset();
    mode_pair_i = 1'b1;
    ticks(80);
    issue(0, 1, 0, 0);
    issue(0, 0, 0, 1);
    ticks(60);
    issue(0, 0, 1, 0);
    run_until(200, k);
    check(k == 52, "R6 after halt", k, 52);

    // R6 completed clear discards both halves
    do_reset();
    ticks(80);
    issue(0, 1, 0, 0);
    issue(0, 0, 1, 0);
    ticks(60);
    issue(0, 0, 1, 0);
    run_until(200, k);
    check(k == 52, "R6 after pair clear", k, 52);
    mode_pair_i = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule